// File: doc/BRIEF.md
# Numeric exception flag unit

This block holds the exception status of a floating-point coprocessor. Each time the arithmetic datapath finishes an operation, it reports that operation's IEEE conditions. The block also classifies one operand on its own, from the operand's exponent and fraction fields, to detect a denormal input. Every condition is folded into a sticky flag register. A per-exception mask register selects which conditions count as errors. Any flag whose mask bit is clear drives the error-summary bit and the external error pin.

On the first unmasked error, the block records two pointers for the handler. The instruction pointer is the address of the first prefix byte in front of the escape opcode. The data pointer is the lowest address of the instruction's memory operand. In real mode the opcode is recorded as well. In protected mode only the two pointers are kept and the opcode register is zeroed. A clear strobe, issued by a software command, empties the flags and so drops the error outputs.

Top module: `fpx_exc_unit`

## Requirements
- R1: After reset, all flags are 0, the error-summary and error outputs are 0, the recorded pointers and opcode are 0, and every mask bit is 1 (all exceptions masked).
- R2: An operation whose operand has exponent field 0 and a non-zero fraction sets the denormal flag (bit 1) one cycle later. A zero exponent with a zero fraction does not set it.
- R3: The flag bit positions are: 0 invalid, 1 denormal, 2 divide-by-zero, 3 overflow, 4 underflow, 5 inexact. Each condition bit reported with a valid operation sets the same flag bit one cycle later.
- R4: An exception whose mask bit is 1 sets only its flag. The error-summary and error outputs stay 0.
- R5: An exception whose mask bit is 0 sets its flag and drives both the error-summary and error outputs to 1 one cycle later.
- R6: Flags are sticky and accumulate over operations. Conditions presented without a valid operation have no effect.
- R7: The clear strobe zeroes all flags and drops both error outputs. Conditions from a valid operation in the same cycle are still recorded.
- R8: A mask write changes the error-summary and error outputs in the following cycle, using the flags already held.
- R9: On an unmasked error while the error output is low, the instruction pointer becomes the escape-opcode address minus the prefix count, modulo 2^ADDR_W. The data pointer becomes the operand address.
- R10: The pointers stay unchanged while the error output is high, and also when an exception arrives masked.
- R11: When an error is recorded, the opcode is stored in real mode. In protected mode the opcode output is set to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | An operation completes this cycle |
| exc_i | input | 6 | Condition bits of the operation (bit order as in R3) |
| opnd_exp_i | input | 15 | Exponent field of the operand |
| opnd_frac_i | input | 64 | Fraction field of the operand |
| esc_addr_i | input | 20 | Address of the escape opcode byte |
| pfx_cnt_i | input | 4 | Number of prefix bytes ahead of the opcode |
| oper_addr_i | input | 20 | Lowest address of the memory operand |
| opcode_i | input | 11 | Opcode bits of the instruction |
| prot_mode_i | input | 1 | Protected mode active |
| mask_we_i | input | 1 | Write strobe for the mask register |
| mask_i | input | 6 | New mask value, 1 = masked |
| clr_i | input | 1 | Clear strobe for the flags |
| flags_o | output | 6 | Sticky exception flags |
| err_sum_o | output | 1 | Error-summary bit |
| error_o | output | 1 | External error output |
| ip_o | output | 20 | Recorded instruction pointer |
| dp_o | output | 20 | Recorded operand pointer |
| opcode_o | output | 11 | Recorded opcode |

## Verification
Flags, mask, pointers and opcode are all registers. Every result therefore appears exactly one clock edge after its stimulus edge: flags and pointers after the operation, and the error outputs after the operation or mask write that changes them. The bench drives inputs on the falling edge and holds them across one rising edge. It removes them and samples on the next falling edge, so each check reads the state that edge produced. Mask-write and clear effects are checked the same way, one edge after their strobe.

// File: rtl/fpx_exc_pkg.sv
package fpx_exc_pkg;
  localparam int unsigned NUM_EXC = 6;
  typedef enum logic [2:0] {
    EXC_INVALID = 3'd0,
    EXC_DENORM  = 3'd1,
    EXC_ZDIV    = 3'd2,
    EXC_OVF     = 3'd3,
    EXC_UNF     = 3'd4,
    EXC_INEXACT = 3'd5
  } exc_idx_e;
endpackage

// File: rtl/fpx_denorm_det.sv
module fpx_denorm_det #(
  parameter int unsigned EXP_W  = 15,
  parameter int unsigned FRAC_W = 64
) (
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              denorm_o
);
  assign denorm_o = (exp_i == '0) && (frac_i != '0);
endmodule

// File: rtl/fpx_flag_reg.sv
module fpx_flag_reg #(
  parameter int unsigned NUM_EXC = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               set_en_i,
  input  logic [NUM_EXC-1:0] set_i,
  input  logic               clr_i,
  output logic [NUM_EXC-1:0] flags_o
);
  logic [NUM_EXC-1:0] base;
  assign base = clr_i ? '0 : flags_o;

  // new events in a clear cycle survive the clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      flags_o <= '0;
    else if (set_en_i || clr_i)
      flags_o <= base | (set_en_i ? set_i : '0);
  end
endmodule

// File: rtl/fpx_ptr_cap.sv
module fpx_ptr_cap #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned PFX_W  = 4,
  parameter int unsigned OPC_W  = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [ADDR_W-1:0] esc_addr_i,
  input  logic [PFX_W-1:0]  pfx_cnt_i,
  input  logic [ADDR_W-1:0] oper_addr_i,
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic              prot_mode_i,
  output logic [ADDR_W-1:0] ip_o,
  output logic [ADDR_W-1:0] dp_o,
  output logic [OPC_W-1:0]  opcode_o
);
  logic [ADDR_W-1:0] first_byte;
  assign first_byte = esc_addr_i - ADDR_W'(pfx_cnt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ip_o     <= '0;
      dp_o     <= '0;
      opcode_o <= '0;
    end else if (cap_i) begin
      ip_o     <= first_byte;
      dp_o     <= oper_addr_i;
      opcode_o <= prot_mode_i ? '0 : opcode_i;
    end
  end
endmodule

// File: rtl/fpx_exc_unit.sv
module fpx_exc_unit #(
  parameter int unsigned NUM_EXC = fpx_exc_pkg::NUM_EXC,
  parameter int unsigned EXP_W   = 15,
  parameter int unsigned FRAC_W  = 64,
  parameter int unsigned ADDR_W  = 20,
  parameter int unsigned PFX_W   = 4,
  parameter int unsigned OPC_W   = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               op_valid_i,
  input  logic [NUM_EXC-1:0] exc_i,
  input  logic [EXP_W-1:0]   opnd_exp_i,
  input  logic [FRAC_W-1:0]  opnd_frac_i,
  input  logic [ADDR_W-1:0]  esc_addr_i,
  input  logic [PFX_W-1:0]   pfx_cnt_i,
  input  logic [ADDR_W-1:0]  oper_addr_i,
  input  logic [OPC_W-1:0]   opcode_i,
  input  logic               prot_mode_i,
  input  logic               mask_we_i,
  input  logic [NUM_EXC-1:0] mask_i,
  input  logic               clr_i,
  output logic [NUM_EXC-1:0] flags_o,
  output logic               err_sum_o,
  output logic               error_o,
  output logic [ADDR_W-1:0]  ip_o,
  output logic [ADDR_W-1:0]  dp_o,
  output logic [OPC_W-1:0]   opcode_o
);
  import fpx_exc_pkg::*;

  logic               denorm;
  logic [NUM_EXC-1:0] exc_eff;
  logic [NUM_EXC-1:0] mask_q;
  logic               new_err;

  fpx_denorm_det #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_denorm (
    .exp_i   (opnd_exp_i),
    .frac_i  (opnd_frac_i),
    .denorm_o(denorm)
  );

  always_comb begin
    exc_eff = exc_i;
    exc_eff[EXC_DENORM] = exc_i[EXC_DENORM] | denorm;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '1;
    else if (mask_we_i) mask_q <= mask_i;
  end

  fpx_flag_reg #(.NUM_EXC(NUM_EXC)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_en_i(op_valid_i),
    .set_i   (exc_eff),
    .clr_i   (clr_i),
    .flags_o (flags_o)
  );

  assign err_sum_o = |(flags_o & ~mask_q);
  assign error_o   = err_sum_o;

  // only the first unmasked error is recorded
  assign new_err = op_valid_i && (|(exc_eff & ~mask_q)) && !err_sum_o;

  fpx_ptr_cap #(.ADDR_W(ADDR_W), .PFX_W(PFX_W), .OPC_W(OPC_W)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_i      (new_err),
    .esc_addr_i (esc_addr_i),
    .pfx_cnt_i  (pfx_cnt_i),
    .oper_addr_i(oper_addr_i),
    .opcode_i   (opcode_i),
    .prot_mode_i(prot_mode_i),
    .ip_o       (ip_o),
    .dp_o       (dp_o),
    .opcode_o   (opcode_o)
  );
endmodule

// File: rtl/fpx_exc_chk.sv
module fpx_exc_chk #(
  parameter int unsigned NUM_EXC = 6,
  parameter int unsigned EXP_W   = 15,
  parameter int unsigned FRAC_W  = 64,
  parameter int unsigned ADDR_W  = 20,
  parameter int unsigned OPC_W   = 11
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               op_valid_i,
  input logic [NUM_EXC-1:0] exc_i,
  input logic [EXP_W-1:0]   opnd_exp_i,
  input logic [FRAC_W-1:0]  opnd_frac_i,
  input logic               prot_mode_i,
  input logic               mask_we_i,
  input logic               clr_i,
  input logic [NUM_EXC-1:0] mask_q,
  input logic [NUM_EXC-1:0] flags_o,
  input logic               error_o,
  input logic [ADDR_W-1:0]  ip_o,
  input logic [ADDR_W-1:0]  dp_o,
  input logic [OPC_W-1:0]   opcode_o
);
  p_denorm_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && opnd_exp_i == '0 && opnd_frac_i != '0) |=> flags_o[1]);

  p_unmasked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !mask_we_i && (|(exc_i & ~mask_q))) |=> error_o);

  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !op_valid_i) |=> (flags_o == '0 && !error_o));

  p_ptr_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (error_o && !clr_i) |=> ($stable(ip_o) && $stable(dp_o)));

  p_pm_opcode_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && prot_mode_i && !mask_we_i && !error_o && (|(exc_i & ~mask_q)))
      |=> (opcode_o == '0));
endmodule

bind fpx_exc_unit fpx_exc_chk #(
  .NUM_EXC(NUM_EXC), .EXP_W(EXP_W), .FRAC_W(FRAC_W), .ADDR_W(ADDR_W), .OPC_W(OPC_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .op_valid_i (op_valid_i),
  .exc_i      (exc_i),
  .opnd_exp_i (opnd_exp_i),
  .opnd_frac_i(opnd_frac_i),
  .prot_mode_i(prot_mode_i),
  .mask_we_i  (mask_we_i),
  .clr_i      (clr_i),
  .mask_q     (mask_q),
  .flags_o    (flags_o),
  .error_o    (error_o),
  .ip_o       (ip_o),
  .dp_o       (dp_o),
  .opcode_o   (opcode_o)
);

// File: tb/fpx_exc_unit_tb_top.sv
`timescale 1ns/1ps
module fpx_exc_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        op_valid = 1'b0;
  logic [5:0]  exc = '0;
  logic [14:0] opnd_exp = 15'd1;
  logic [63:0] opnd_frac = '0;
  logic [19:0] esc_addr = '0;
  logic [3:0]  pfx_cnt = '0;
  logic [19:0] oper_addr = '0;
  logic [10:0] opcode = '0;
  logic        prot_mode = 1'b0;
  logic        mask_we = 1'b0;
  logic [5:0]  mask = '0;
  logic        clr = 1'b0;
  logic [5:0]  flags;
  logic        err_sum, error;
  logic [19:0] ip, dp;
  logic [10:0] opc_o;

  int total = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fpx_exc_unit dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .op_valid_i(op_valid), .exc_i(exc),
    .opnd_exp_i(opnd_exp), .opnd_frac_i(opnd_frac), .esc_addr_i(esc_addr),
    .pfx_cnt_i(pfx_cnt), .oper_addr_i(oper_addr), .opcode_i(opcode),
    .prot_mode_i(prot_mode), .mask_we_i(mask_we), .mask_i(mask), .clr_i(clr),
    .flags_o(flags), .err_sum_o(err_sum), .error_o(error), .ip_o(ip),
    .dp_o(dp), .opcode_o(opc_o)
  );

  // {mask, exc, expected flags, expected error}
  localparam logic [18:0] VEC [7] = '{
    {6'h3F, 6'h20, 6'h20, 1'b0},
    {6'h1F, 6'h20, 6'h20, 1'b1},
    {6'h3F, 6'h09, 6'h09, 1'b0},
    {6'h37, 6'h09, 6'h09, 1'b1},
    {6'h00, 6'h00, 6'h00, 1'b0},
    {6'h3E, 6'h06, 6'h06, 1'b0},
    {6'h3E, 6'h01, 6'h01, 1'b1}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    total++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, expv);
    end
  endtask

  task automatic do_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic wr_mask(logic [5:0] m);
    @(negedge clk); mask_we = 1'b1; mask = m;
    @(negedge clk); mask_we = 1'b0;
  endtask

  task automatic do_op(logic [5:0] e);
    @(negedge clk); op_valid = 1'b1; exc = e;
    @(negedge clk); op_valid = 1'b0; exc = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 flags", 32'(flags), 0);
    chk("R1 err_sum", 32'(err_sum), 0);
    chk("R1 error", 32'(error), 0);
    chk("R1 ip", 32'(ip), 0);
    chk("R1 dp", 32'(dp), 0);
    chk("R1 opcode", 32'(opc_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    do_op(6'h3F);
    chk("R1 all masked flags", 32'(flags), 32'h3F);
    chk("R1 all masked error", 32'(error), 0);

    // R3 R4 R5 table
    foreach (VEC[i]) begin
      do_clr();
      wr_mask(VEC[i][18:13]);
      do_op(VEC[i][12:7]);
      chk("R3 flags", 32'(flags), 32'(VEC[i][6:1]));
      chk("R4/R5 error", 32'(error), 32'(VEC[i][0]));
      chk("R5 err_sum", 32'(err_sum), 32'(VEC[i][0]));
    end

    // R2 denormal detection
    wr_mask(6'h3F);
    do_clr();
    opnd_exp = '0; opnd_frac = 64'h5;
    do_op(6'h00);
    chk("R2 denormal", 32'(flags), 32'h02);
    do_clr();
    opnd_frac = '0;
    do_op(6'h00);
    chk("R2 true zero", 32'(flags), 0);
    opnd_exp = 15'd1;

    // R6 ignored without valid, sticky
    @(negedge clk); exc = 6'h3F;
    @(negedge clk); exc = '0;
    chk("R6 no valid", 32'(flags), 0);
    do_op(6'h04);
    do_op(6'h08);
    chk("R6 sticky", 32'(flags), 32'h0C);

    // R8 mask write recomputes error
    chk("R8 before", 32'(error), 0);
    wr_mask(6'h3B);
    chk("R8 after unmask", 32'(error), 1);
    wr_mask(6'h3F);
    chk("R8 after remask", 32'(err_sum), 0);

    // R7 clear with same-cycle event
    @(negedge clk); clr = 1'b1; op_valid = 1'b1; exc = 6'h10;
    @(negedge clk); clr = 1'b0; op_valid = 1'b0; exc = '0;
    chk("R7 clr keeps new", 32'(flags), 32'h10);
    wr_mask(6'h00);
    chk("R7 err up", 32'(error), 1);
    do_clr();
    chk("R7 cleared flags", 32'(flags), 0);
    chk("R7 cleared error", 32'(error), 0);

    // R9 pointer capture
    esc_addr = 20'h12345; pfx_cnt = 4'd3; oper_addr = 20'hABCDE; opcode = 11'h5A3;
    do_op(6'h01);
    chk("R9 ip", 32'(ip), 32'h12342);
    chk("R9 dp", 32'(dp), 32'hABCDE);
    chk("R11 real opcode", 32'(opc_o), 32'h5A3);

    // R10 hold while error
    esc_addr = 20'h11111; pfx_cnt = 4'd0; oper_addr = 20'h22222; opcode = 11'h111;
    do_op(6'h02);
    chk("R10 ip hold", 32'(ip), 32'h12342);
    chk("R10 dp hold", 32'(dp), 32'hABCDE);

    // R9 wraparound
    do_clr();
    esc_addr = 20'h00001; pfx_cnt = 4'd2; oper_addr = 20'h00010;
    do_op(6'h08);
    chk("R9 ip wrap", 32'(ip), 32'hFFFFF);
    chk("R9 dp", 32'(dp), 32'h00010);

    // R10 masked event does not capture
    do_clr();
    wr_mask(6'h3F);
    esc_addr = 20'h33333; oper_addr = 20'h44444;
    do_op(6'h20);
    chk("R10 masked ip", 32'(ip), 32'hFFFFF);
    chk("R10 masked dp", 32'(dp), 32'h00010);

    // R11 protected mode
    do_clr();
    wr_mask(6'h00);
    prot_mode = 1'b1; opcode = 11'h7FF; esc_addr = 20'h50000; pfx_cnt = 4'd1;
    do_op(6'h04);
    chk("R11 pm opcode", 32'(opc_o), 0);
    chk("R11 pm ip", 32'(ip), 32'h4FFFF);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule